// File: doc/BRIEF.md
# Staged Mapping Control Register Bank

This block holds the single-bit control registers of a cartridge memory mapper. A 24-bit bus address picks one of sixteen register slots, and only bit 7 of the data byte carries the value. Mapping controls are written into a staging set first. A separate commit write moves the whole staging set into the active set in one clock edge, so the translation logic downstream never sees a half-updated mapping.

The active set drives the mapping-control outputs. It also drives two controls for an attached flash device. One control lets the mapper forward flash write requests. The other drives the device's write-enable pin. An interrupt flag, which follows a level source, and an interrupt enable are also in the bank. The enable is the one control that takes effect as soon as it is written.

Top module: `mapctl_regbank`

## Requirements
- R1: A bus access hits the bank when (address AND 0xF0F000) equals 0x005000. The slot index is address bits 19:16, and only data bit 7 is stored. Any address in a bank's 0x5000-0x5FFF range selects the same slot.
- R2: A write to slots 2 to 13 changes only the staging copy. The mapping outputs keep their values until a commit.
- R3: A write to slot 14 with data bit 7 = 1 copies all staged slots into the active set at that clock edge. If data bit 7 = 0, the write has no effect.
- R4: A write to slot 1 sets the interrupt enable directly. The interrupt flag registers the level of `irq_src` each cycle. `irq_o` is flag AND enable, registered once more.
- R5: A read returns data on `rd_data` one cycle after `bus_re`. In the returned byte, bits 6:0 are zero. Bit 7 holds, by slot: the interrupt flag for slot 0; the interrupt enable for slot 1; the active value for slots 2 to 13; zero for slots 14 and 15.
- R6: A read outside the window returns the `bus_rdin` byte unchanged.
- R7: `flash_wr_stb` pulses one cycle after `flash_wr_req`, but only if active slot 12 is 1. Otherwise the request is dropped.
- R8: `flash_wr_en` equals active slot 13.
- R9: After reset, both the staging and active copies hold 1 in slots 9 and 11 and 0 in every other slot (`map_ctl` = 0x0A00). The interrupt enable, `rd_data`, `irq_o` and `flash_wr_stb` are all 0.
- R10: `psram_sel` is {active slot 6, active slot 5}.
- R11: Writes to slots 0 and 15, and writes outside the window, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | Bus address |
| bus_wdata | input | 8 | Write data; bit 7 is used |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdin | input | 8 | Open-bus byte returned for misses |
| irq_src | input | 1 | Interrupt source level |
| flash_wr_req | input | 1 | Flash write request from the mapper |
| rd_data | output | 8 | Registered read data |
| map_ctl | output | 16 | Active slots; bits 0, 1, 14 and 15 are zero |
| psram_sel | output | 2 | Two-bit mapping field |
| flash_wr_en | output | 1 | Flash write-enable pin drive |
| flash_wr_stb | output | 1 | Gated flash write strobe |
| irq_o | output | 1 | Interrupt output |

## Verification
The timing follows from the registers on each path:
- Staging writes, the enable write and a commit all show at the outputs just after the edge that takes the write.
- Read data appears one edge after the read strobe, and the flash strobe one edge after its request.
- The interrupt output follows its source after two edges, because the flag register and the output register both sit on that path.

The bench drives inputs and compares outputs on the falling edge. Its model advances once per rising edge, computing each output from the previous state and then updating the state. Directed checks wait exactly the number of edges that each path needs.

// File: rtl/mapctl_pkg.sv
package mapctl_pkg;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 8;
  localparam int NREG      = 16;
  localparam int IDX_W     = $clog2(NREG);
  localparam int IDX_LSB   = 16;
  localparam int VAL_BIT   = 7;
  localparam logic [ADDR_W-1:0] WIN_MASK  = 24'hF0F000;
  localparam logic [ADDR_W-1:0] WIN_MATCH = 24'h005000;
  localparam int SLOT_IRQF = 0;
  localparam int SLOT_IRQE = 1;
  localparam int STG_LO    = 2;
  localparam int STG_HI    = 13;
  localparam int SLOT_CMT  = 14;
  localparam int SLOT_FGATE = 12;
  localparam int SLOT_FWE  = 13;
  localparam int SLOT_PS0  = 5;
  localparam logic [NREG-1:0] RST_VAL = 16'h0A00;
endpackage

// File: rtl/mapctl_decode.sv
module mapctl_decode
  import mapctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              vbit
);
  logic unused_wdata;

  assign hit  = (addr & WIN_MASK) == WIN_MATCH;
  assign idx  = addr[IDX_LSB +: IDX_W];
  assign vbit = wdata[VAL_BIT];
  assign unused_wdata = ^{wdata[VAL_BIT-1:0]};
endmodule

// File: rtl/mapctl_store.sv
module mapctl_store
  import mapctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             commit,
  output logic [NREG-1:0]  staged,
  output logic [NREG-1:0]  active
);
  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i >= STG_LO && i <= STG_HI) begin : g_live
      logic stg_q, act_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stg_q <= RST_VAL[i];
          act_q <= RST_VAL[i];
        end else begin
          if (wr_en && wr_idx == IDX_W'(i)) stg_q <= wr_bit;
          if (commit) act_q <= stg_q;
        end
      end
      assign staged[i] = stg_q;
      assign active[i] = act_q;
    end else begin : g_none
      assign staged[i] = 1'b0;
      assign active[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mapctl_rdport.sv
module mapctl_rdport
  import mapctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] open_bus,
  input  logic              irq_flag,
  input  logic              irq_en,
  input  logic [NREG-1:0]   active,
  output logic [DATA_W-1:0] rd_data
);
  logic sel_bit;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (idx == IDX_W'(SLOT_IRQF))      sel_bit = irq_flag;
    else if (idx == IDX_W'(SLOT_IRQE)) sel_bit = irq_en;
    else if (int'(idx) >= STG_LO && int'(idx) <= STG_HI) sel_bit = active[idx];
    else                               sel_bit = 1'b0;
    rd_next = hit ? (DATA_W'(sel_bit) << VAL_BIT) : open_bus;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/mapctl_regbank.sv
module mapctl_regbank
  import mapctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdin,
  input  logic              irq_src,
  input  logic              flash_wr_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [NREG-1:0]   map_ctl,
  output logic [1:0]        psram_sel,
  output logic              flash_wr_en,
  output logic              flash_wr_stb,
  output logic              irq_o
);
  logic             hit, vbit, commit, stg_wr;
  logic [IDX_W-1:0] idx;
  logic [NREG-1:0]  stg_bits, act_bits;
  logic             irq_flag_q, irq_en_q, irq_o_q, stb_q;

  mapctl_decode u_dec (
    .addr(bus_addr), .wdata(bus_wdata), .hit(hit), .idx(idx), .vbit(vbit)
  );

  assign stg_wr = bus_we && hit && int'(idx) >= STG_LO && int'(idx) <= STG_HI;
  assign commit = bus_we && hit && idx == IDX_W'(SLOT_CMT) && vbit;

  mapctl_store u_store (
    .clk(clk), .rst(rst), .wr_en(stg_wr), .wr_idx(idx), .wr_bit(vbit),
    .commit(commit), .staged(stg_bits), .active(act_bits)
  );

  mapctl_rdport u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_re), .hit(hit), .idx(idx),
    .open_bus(bus_rdin), .irq_flag(irq_flag_q), .irq_en(irq_en_q),
    .active(act_bits), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag_q <= 1'b0;
      irq_en_q   <= 1'b0;
      irq_o_q    <= 1'b0;
      stb_q      <= 1'b0;
    end else begin
      irq_flag_q <= irq_src;
      if (bus_we && hit && idx == IDX_W'(SLOT_IRQE)) irq_en_q <= vbit;
      irq_o_q    <= irq_flag_q & irq_en_q;
      stb_q      <= flash_wr_req & act_bits[SLOT_FGATE];
    end
  end

  assign map_ctl      = act_bits;
  assign psram_sel    = act_bits[SLOT_PS0 +: 2];
  assign flash_wr_en  = act_bits[SLOT_FWE];
  assign flash_wr_stb = stb_q;
  assign irq_o        = irq_o_q;
endmodule

// File: rtl/mapctl_regbank_chk.sv
module mapctl_regbank_chk
  import mapctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdin,
  input logic              flash_wr_req,
  input logic [DATA_W-1:0] rd_data,
  input logic [NREG-1:0]   map_ctl,
  input logic              flash_wr_stb,
  input logic [NREG-1:0]   staged
);
  logic in_win, is_commit;
  assign in_win    = (bus_addr & WIN_MASK) == WIN_MATCH;
  assign is_commit = bus_we && in_win && bus_addr[19:16] == 4'd14 && bus_wdata[7];

  a_r2_hold_until_commit: assert property (@(posedge clk) disable iff (rst)
    !is_commit |=> map_ctl == $past(map_ctl));
  a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
    is_commit |=> map_ctl == $past(staged));
  a_r5_high_slots_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && in_win && bus_addr[19:16] >= 4'd14) |=> rd_data == 8'h00);
  a_r6_open_bus: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !in_win) |=> rd_data == $past(bus_rdin));
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    (!map_ctl[12] || !flash_wr_req) |=> !flash_wr_stb);
endmodule

bind mapctl_regbank mapctl_regbank_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdin(bus_rdin),
  .flash_wr_req(flash_wr_req), .rd_data(rd_data), .map_ctl(map_ctl),
  .flash_wr_stb(flash_wr_stb), .staged(stg_bits)
);

// File: tb/mapctl_regbank_bench.sv
module mapctl_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdin = '0;
  logic bus_we = 0, bus_re = 0, irq_src = 0, flash_wr_req = 0;
  logic [7:0]  rd_data;
  logic [15:0] map_ctl;
  logic [1:0]  psram_sel;
  logic flash_wr_en, flash_wr_stb, irq_o;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mapctl_regbank u_mapctl_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdin(bus_rdin), .irq_src(irq_src),
    .flash_wr_req(flash_wr_req), .rd_data(rd_data), .map_ctl(map_ctl),
    .psram_sel(psram_sel), .flash_wr_en(flash_wr_en),
    .flash_wr_stb(flash_wr_stb), .irq_o(irq_o)
  );

  // behavioural reference model
  bit m_stg[16], m_act[16];
  bit m_en, m_flag, m_stb, m_irq;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    bit hit, b, sb;
    int ix;
    if (rst) begin
      foreach (m_stg[i]) begin m_stg[i] = (i == 9 || i == 11); m_act[i] = m_stg[i]; end
      m_en = 0; m_flag = 0; m_stb = 0; m_irq = 0; m_rd = 0;
    end else begin
      hit = (bus_addr & 24'hF0F000) == 24'h005000;
      ix  = bus_addr[19:16];
      b   = bus_wdata[7];
      m_irq = m_flag & m_en;
      m_stb = flash_wr_req & m_act[12];
      if (bus_re) begin
        if (!hit) m_rd = bus_rdin;
        else begin
          sb = (ix == 0) ? m_flag : (ix == 1) ? m_en : (ix <= 13) ? m_act[ix] : 1'b0;
          m_rd = {sb, 7'd0};
        end
      end
      if (bus_we && hit) begin
        if (ix == 1) m_en = b;
        else if (ix >= 2 && ix <= 13) m_stg[ix] = b;
        else if (ix == 14 && b) foreach (m_act[i]) m_act[i] = m_stg[i];
      end
      m_flag = irq_src;
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [15:0] mm;
    if (!rst) begin
      for (int i = 0; i < 16; i++) mm[i] = m_act[i];
      check("R5", 16'(rd_data), 16'(m_rd));
      check("R2", map_ctl, mm);
      check("R10", 16'(psram_sel), 16'({m_act[6], m_act[5]}));
      check("R8", 16'(flash_wr_en), 16'(m_act[13]));
      check("R7", 16'(flash_wr_stb), 16'(m_stb));
      check("R4", 16'(irq_o), 16'(m_irq));
    end
  end

  task automatic wr(logic [23:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [23:0] a, logic [7:0] ob);
    bus_addr = a; bus_rdin = ob; bus_re = 1;
    @(negedge clk); bus_re = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R9", map_ctl, 16'h0A00);
    check("R9", 16'(rd_data), 16'h0000);
    check("R9", 16'({flash_wr_en, flash_wr_stb, irq_o}), 16'h0000);
    wr(24'h025000, 8'h80);
    check("R2", map_ctl, 16'h0A00);
    rd(24'h025000, 8'h00);
    check("R5", 16'(rd_data), 16'h0000);
    wr(24'h0E5000, 8'h7F);
    check("R3", map_ctl, 16'h0A00);
    wr(24'h0E5000, 8'h80);
    check("R3", map_ctl, 16'h0A04);
    rd(24'h025000, 8'h00);
    check("R5", 16'(rd_data), 16'h0080);
    wr(24'h065000, 8'h80);
    wr(24'h055000, 8'h7F);
    wr(24'h0E5000, 8'h80);
    check("R10", 16'(psram_sel), 16'h0002);
    flash_wr_req = 1; @(negedge clk); flash_wr_req = 0;
    check("R7", 16'(flash_wr_stb), 16'h0000);
    wr(24'h0C5000, 8'h80);
    wr(24'h0D5000, 8'h80);
    wr(24'h0E5000, 8'h80);
    check("R8", 16'(flash_wr_en), 16'h0001);
    flash_wr_req = 1; @(negedge clk); flash_wr_req = 0;
    check("R7", 16'(flash_wr_stb), 16'h0001);
    wr(24'h015000, 8'h80);
    irq_src = 1; @(negedge clk); @(negedge clk);
    check("R4", 16'(irq_o), 16'h0001);
    rd(24'h005000, 8'h00);
    check("R5", 16'(rd_data), 16'h0080);
    rd(24'h015000, 8'h00);
    check("R5", 16'(rd_data), 16'h0080);
    irq_src = 0;
    wr(24'h125000, 8'h00);
    wr(24'h024000, 8'h00);
    wr(24'h0E5000, 8'h80);
    check("R11", 16'(map_ctl[2]), 16'h0001);
    rd(24'h004000, 8'h5A);
    check("R6", 16'(rd_data), 16'h005A);
    wr(24'h0F5000, 8'h80);
    wr(24'h005000, 8'h80);
    rd(24'h0F5000, 8'hFF);
    check("R11", 16'(rd_data), 16'h0000);
    rd(24'h0E5000, 8'hFF);
    check("R5", 16'(rd_data), 16'h0000);
    wr(24'h025FFF, 8'h00);
    wr(24'h0E5ABC, 8'h80);
    check("R1", 16'(map_ctl[2]), 16'h0000);
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule